// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Interrupt Status

This block sits between a processor bus and a stereo audio serializer. Software writes 32-bit sample words into a queue through any of four data offsets. Each word carries one channel. Words are queued in pairs, left first and then right. The serializer takes words from the head of the queue through a valid/ready handshake, and only while transmission is enabled.

Two status bits follow the queue occupancy on every cycle. The empty bit is set when nothing is queued. The low-water bit is set when the occupancy is below a threshold, which is the capacity shifted right by a 4-bit level code. A third status bit is sticky and records that a data write was dropped because the queue was full. One interrupt line is raised when the interrupt enable is set and an unmasked live status bit is high. Serial timing, clock generation and bulk transfer engines are outside this block. The capacity is a power-of-two parameter, and a small value is used in simulation.

Top module: `audio_tx_fifo_regs`

## Requirements
- R1: After reset, the configuration reads 0, the mask reads 0, the status reads 0x3, the interrupt output is 0 and out_valid is 0.
- R2: A read at word offset 0x00 returns the VERSION parameter. Reads of the data offsets 0x10 to 0x1C, of offsets 0x20 and above, and of any address whose bits 1:0 are not zero all return 0.
- R3: The configuration at 0x04 keeps bit 0 (transmit enable), bit 1 (interrupt enable), bit 2 (left-select), bits 15:8 (ratio), bits 21:16 (resolution), bits 27:24 (level code) and bits 31:28 (channel field). Its other bits read 0, so writing all ones reads back 0xFF3FFF07. The mask at 0x08 keeps bits 1:0.
- R4: Status bit 0 at 0x0C is 1 exactly when the queue holds no words.
- R5: Status bit 1 is 1 exactly when the occupancy is less than DEPTH >> level code. A code of 0 compares against DEPTH itself.
- R6: The irq output is 1 exactly when config bit 1 is set and (status[1:0] & mask[1:0]) is nonzero.
- R7: Writing the status register does not change bits 1:0. Writing 1 to bit 2 clears the sticky overflow flag.
- R8: A data write while the queue holds DEPTH words is dropped, and it sets status bit 2.
- R9: out_valid is 1 only when config bit 0 is set and the queue is not empty. Words leave in the order they were written, one per cycle in which out_valid and out_ready are both 1.
- R10: A write to any of the four data offsets 0x10, 0x14, 0x18 or 0x1C appends one word.
- R11: out_right is 0 for the first word popped after transmit is enabled and toggles on each pop. It returns to 0 while transmit is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| irq | output | 1 | Interrupt request |
| out_valid | output | 1 | A word is offered to the serializer |
| out_ready | input | 1 | The serializer takes the offered word |
| out_data | output | 32 | Sample word at the head of the queue |
| out_right | output | 1 | 0 for a left word, 1 for a right word |

## Verification
For every level code from 0 to 4, the bench fills an eight-word queue one word at a time and checks both live status bits at each occupancy from 0 to full. This shows where the low-water threshold sits, including the code whose threshold is zero. The words go to the four data offsets in rotation, and each fill ends with one extra write. When the queue is then drained, any lost word, any extra word or any reordering would show up, and so would an overflow that did not register. The interrupt is tried with each mask bit alone, with no mask bits, and with the enable cleared. This tells the gating term apart from the status term.

// File: rtl/audio_tx_fifo_regs.sv
module audio_tx_fifo_regs #(
  parameter int          DEPTH   = 256,
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h0001_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              out_right
);
  localparam int          PW       = $clog2(DEPTH);
  localparam int          CW       = $clog2(DEPTH + 1);
  localparam logic [31:0] CFG_KEEP = 32'hFF3F_FF07;
  localparam logic [31:0] DEPTH32  = 32'(DEPTH);

  logic [31:0]   cfg_q;
  logic [1:0]    mask_q;
  logic          ovf_q;
  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  wire aligned = (addr[1:0] == 2'b00);
  wire in_range = (addr >> 5) == '0;
  wire [2:0] widx = addr[4:2];
  wire hit = aligned && in_range;

  wire tx_en   = cfg_q[0];
  wire irq_en  = cfg_q[1];
  wire [3:0] lvl_code = cfg_q[27:24];

  wire full    = (count == CW'(DEPTH));
  wire empty   = (count == '0);
  wire [31:0] thr = DEPTH32 >> lvl_code;
  wire below   = 32'(count) < thr;
  wire [2:0] status = {ovf_q, below, empty};

  wire data_wr = wr_en && hit && widx[2];
  wire push    = data_wr && !full;
  wire pop     = out_valid && out_ready;

  assign out_valid = tx_en && !empty;
  assign out_data  = mem[rptr];
  assign irq       = irq_en && |(status[1:0] & mask_q);

  always_comb begin
    rd_data = '0;
    if (hit) begin
      case (widx)
        3'd0:    rd_data = VERSION;
        3'd1:    rd_data = cfg_q;
        3'd2:    rd_data = {30'b0, mask_q};
        3'd3:    rd_data = {29'b0, status};
        default: rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_en && hit && widx == 3'd1) cfg_q  <= wr_data & CFG_KEEP;
      if (wr_en && hit && widx == 3'd2) mask_q <= wr_data[1:0];
      if (data_wr && full)
        ovf_q <= 1'b1;
      else if (wr_en && hit && widx == 3'd3 && wr_data[2])
        ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      out_right <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (!tx_en)   out_right <= 1'b0;
      else if (pop) out_right <= !out_right;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && data_wr && !pop) |=> (count == CW'(DEPTH) && ovf_q));

  assert_pop_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tx_en && !status[0]));

  assert_pop_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && mask_q != 2'b00));

  assert_side_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_en) |-> !out_right);
endmodule

// File: tb/audio_tx_fifo_regs_test.sv
`timescale 1ns/1ps
module audio_tx_fifo_regs_test;
  localparam int D = 8;
  localparam logic [31:0] VER = 32'h0001_0002;

  logic clk = 0, rst_n = 0, wr_en = 0, out_ready = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data, out_data;
  logic irq, out_valid, out_right;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_tx_fifo_regs #(.DEPTH(D), .ADDR_W(8), .VERSION(VER)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_right(out_right));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  logic [31:0] v;
  int unsigned thr;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h04, v); check("R1 cfg", v, 0);
    rd(8'h08, v); check("R1 mask", v, 0);
    rd(8'h0C, v); check("R1 status", v, 32'h3);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 valid", {31'b0, out_valid}, 0);

    rd(8'h00, v); check("R2 version", v, VER);
    rd(8'h10, v); check("R2 data read", v, 0);
    rd(8'h1C, v); check("R2 data read", v, 0);
    rd(8'h20, v); check("R2 unmapped", v, 0);
    rd(8'h05, v); check("R2 misaligned", v, 0);

    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); check("R3 cfg keep", v, 32'hFF3F_FF07);
    check("R9 empty no valid", {31'b0, out_valid}, 0);
    wr(8'h04, 0);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); check("R3 mask keep", v, 32'h3);
    wr(8'h08, 0);

    for (int code = 0; code <= 4; code++) begin
      thr = D >> code;
      wr(8'h04, code << 24);
      for (int n = 0; n <= D; n++) begin
        rd(8'h0C, v);
        check("R4 empty bit", {31'b0, v[0]}, {31'b0, n == 0});
        check("R5 level bit", {31'b0, v[1]}, {31'b0, n < thr});
        if (n == 3) begin
          wr(8'h0C, 32'h3); rd(8'h0C, v);
          check("R7 status write", v, {30'b0, (3 < thr), 1'b0});
        end
        if (n < D) wr(8'h10 + 8'((n % 4) * 4), 32'hA000_0000 + (code << 8) + n);
      end
      wr(8'h14, 32'hDEAD_BEEF);
      rd(8'h0C, v); check("R8 overflow flag", {31'b0, v[2]}, 1);
      out_ready = 1;
      wr(8'h04, (code << 24) | 1);
      for (int i = 0; i < D; i++) begin
        #1;
        check("R9 valid", {31'b0, out_valid}, 1);
        check("R10 data order", out_data, 32'hA000_0000 + (code << 8) + i);
        check("R11 side", {31'b0, out_right}, i % 2);
        @(negedge clk);
      end
      #1 check("R8 dropped word", {31'b0, out_valid}, 0);
      out_ready = 0;
      wr(8'h04, code << 24);
      check("R11 side reset", {31'b0, out_right}, 0);
      wr(8'h0C, 32'h4); rd(8'h0C, v);
      check("R7 overflow clear", {31'b0, v[2]}, 0);
    end

    wr(8'h08, 1); wr(8'h04, 2);
    #1 check("R6 underrun irq", {31'b0, irq}, 1);
    wr(8'h08, 0);
    #1 check("R6 masked", {31'b0, irq}, 0);
    wr(8'h08, 2); wr(8'h04, 2 | (1 << 24));
    #1 check("R6 level irq", {31'b0, irq}, 1);
    wr(8'h18, 1); wr(8'h18, 2); wr(8'h18, 3);
    #1 check("R6 level irq count3", {31'b0, irq}, 1);
    wr(8'h18, 4);
    #1 check("R6 level clear count4", {31'b0, irq}, 0);
    wr(8'h08, 1);
    #1 check("R6 underrun mask nonempty", {31'b0, irq}, 0);
    wr(8'h08, 3); wr(8'h04, 32'h0200_0000);
    #1 check("R6 enable off", {31'b0, irq}, 0);
    out_ready = 1;
    wr(8'h04, 1);
    for (int i = 1; i <= 4; i++) begin
      #1 check("R10 offset 0x18 data", out_data, i);
      @(negedge clk);
    end
    #1 check("R9 drained", {31'b0, out_valid}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule